// File: doc/BRIEF.md
# Synchronous FIFO with Direction-Tracking Flags

This block is a single-clock first-in/first-out queue. Its storage is a circular buffer held in a two-port array: one address counter selects the slot for the next write and another selects the slot for the next read. Each counter moves forward by one only after an access on its own port is actually carried out, and it wraps from `DEPTH-1` back to zero. `DEPTH` need not be a power of two.

Full and empty are not told apart by an extra address bit. When the two addresses match, the buffer is at one of its two extremes. A one-bit direction register records whether the last occupancy change was a net insertion (filling) or a net removal (draining). The address match combined with that bit gives the flag. Read data is registered and comes out on the clock edge that performs the read.

Top module: `dtf_fifo`

## Requirements
- R1: After reset `empty_o` is 1, `full_o` is 0 and `rd_data_o` is zero.
- R2: Words leave in the order they were written. A read accepted at a rising edge places the oldest stored word on `rd_data_o` right after that edge, and `rd_data_o` holds that value until the next accepted read.
- R3: The queue holds exactly `DEPTH` words. After `DEPTH` accepted writes with no reads, starting from empty, `full_o` is 1 and `empty_o` is 0.
- R4: An accepted write with no accepted read in the same cycle leaves the block not empty after that edge. When it makes the addresses equal, `full_o` becomes 1.
- R5: A write and a read in the same cycle, while the queue is neither full nor empty, leave the occupancy and both flags unchanged.
- R6: A write while full (with no read) is ignored. The contents, `full_o` and the later read order do not change.
- R7: A read while empty (with no write) is ignored. `empty_o` stays 1 and `rd_data_o` keeps its previous value.
- R8: When full and both enables are high, the read is performed and the write is dropped. After the edge `full_o` is 0 and the dropped word never appears at the output.
- R9: When empty and both enables are high, the write is performed and the read is dropped. After the edge `empty_o` is 0 and `rd_data_o` is unchanged.
- R10: Both addresses wrap from `DEPTH-1` to 0. Data order and flags stay correct over many laps at the default `DEPTH` of 6, which is not a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Registered read word |
| full_o | output | 1 | Queue holds DEPTH words |
| empty_o | output | 1 | Queue holds no words |

## Verification
A write and a read can arrive in the same cycle. The outcome depends on occupancy. At an extreme, one of the two requests must be dropped. In between, both are carried out and the direction bit must hold. The bench drives both enables together at empty, at full and at several fill levels, and also in random runs that wrap the addresses many times. Each cycle it compares the flags and the read word against a queue model that pops before it pushes and respects the full and empty limits.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  typedef enum logic {
    DIR_DRAIN = 1'b0,
    DIR_FILL  = 1'b1
  } dir_e;
endpackage

// File: rtl/dtf_ptr.sv
module dtf_ptr #(
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [ADDR_W-1:0] addr_q, addr_nxt;

  generate
    if (IS_POW2) begin : g_pow2
      assign addr_nxt = addr_q + 1'b1;
    end else begin : g_wrap
      assign addr_nxt = (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (adv_i) addr_q <= addr_nxt;
  end

  assign addr_o = addr_q;

  assert_addr_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST);
endmodule

// File: rtl/dtf_dir.sv
module dtf_dir
  import dtf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ok_i,
  input  logic rd_ok_i,
  input  logic addr_eq_i,
  output logic full_o,
  output logic empty_o
);
  dir_e dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= DIR_DRAIN;
    else if (wr_ok_i && !rd_ok_i) dir_q <= DIR_FILL;
    else if (rd_ok_i && !wr_ok_i) dir_q <= DIR_DRAIN;
  end

  assign full_o  = addr_eq_i && (dir_q == DIR_FILL);
  assign empty_o = addr_eq_i && (dir_q == DIR_DRAIN);
endmodule

// File: rtl/dtf_ram.sv
module dtf_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dtf_fifo.sv
module dtf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] waddr, raddr;
  logic wr_ok, rd_ok;

  // a write is refused only when full, a read only when empty
  assign wr_ok = wr_en_i && !full_o;
  assign rd_ok = rd_en_i && !empty_o;

  dtf_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wr_ok), .addr_o(waddr));

  dtf_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rd_ok), .addr_o(raddr));

  dtf_dir u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ok_i(wr_ok), .rd_ok_i(rd_ok),
    .addr_eq_i(waddr == raddr), .full_o(full_o), .empty_o(empty_o));

  dtf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ok), .waddr_i(waddr),
    .wdata_i(wr_data_i), .re_i(rd_ok), .raddr_i(raddr), .rdata_o(rd_data_o));

  assert_write_leaves_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && !full_o) |=> !empty_o);
  assert_both_midway_flags_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i && !full_o && !empty_o) |=> (!full_o && !empty_o));
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i) |=> (full_o && $stable(waddr)));
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_en_i && !wr_en_i) |=> (empty_o && $stable(rd_data_o)));
  assert_full_both_reads_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && rd_en_i) |=> (!full_o && $stable(waddr)));
  assert_empty_both_writes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && wr_en_i && rd_en_i) |=> (!empty_o && $stable(rd_data_o)));
  assert_flags_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: tb/dtf_fifo_test.sv
`timescale 1ns/1ps
module dtf_fifo_test;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic full, empty;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] model_q [$];
  logic [DATA_W-1:0] exp_data = '0;

  always #10 clk = ~clk;

  dtf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .full_o(full), .empty_o(empty));

  function automatic bit model_full();
    return model_q.size() == DEPTH;
  endfunction

  function automatic bit model_empty();
    return model_q.size() == 0;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "full_o", int'(full), int'(model_full()));
    check(req, "empty_o", int'(empty), int'(model_empty()));
    check(req, "rd_data_o", int'(rd_data), int'(exp_data));
  endtask

  // drive at the falling edge, update the model, check at the next falling edge
  task automatic step(input bit w, input bit r, input logic [DATA_W-1:0] d, input string req);
    bit mf, me;
    mf = model_full();
    me = model_empty();
    wr_en = w; rd_en = r; wr_data = d;
    if (r && !me) exp_data = model_q.pop_front();
    if (w && !mf) model_q.push_back(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    step(1'b0, 1'b1, 8'h00, "R7");
    step(1'b0, 1'b1, 8'h00, "R7");
    step(1'b1, 1'b1, 8'hA5, "R9");
    step(1'b0, 1'b1, 8'h00, "R2");
    step(1'b1, 1'b0, 8'h11, "R4");
    for (int i = 1; i < DEPTH; i++) step(1'b1, 1'b0, 8'(8'h20 + i), "R3");
    step(1'b1, 1'b0, 8'hEE, "R6");
    step(1'b1, 1'b0, 8'hEF, "R6");
    step(1'b1, 1'b1, 8'hDD, "R8");
    step(1'b1, 1'b0, 8'h5C, "R4");
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 8'h00, "R2");
    step(1'b0, 1'b1, 8'h00, "R7");

    for (int lvl = 1; lvl < DEPTH; lvl++) begin
      for (int i = 0; i < lvl; i++) step(1'b1, 1'b0, 8'($urandom), "R4");
      for (int i = 0; i < 2 * DEPTH; i++) step(1'b1, 1'b1, 8'($urandom), "R5");
      for (int i = 0; i < lvl; i++) step(1'b0, 1'b1, 8'h00, "R10");
    end

    for (int i = 0; i < 3000; i++) begin
      int mode;
      bit w, r;
      mode = i / 500;
      w = ($urandom % 4) < ((mode % 2) ? 1 : 3);
      r = ($urandom % 4) < ((mode % 2) ? 3 : 1);
      if (mode == 4) begin w = 1'b1; r = 1'b1; end
      step(w, r, 8'($urandom), "R10");
    end

    while (!model_empty()) step(1'b0, 1'b1, 8'h00, "R2");
    step(1'b0, 1'b1, 8'h00, "R7");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule